// File: doc/BRIEF.md
# Descriptor Chain Walker

This block runs a chain of transfer descriptors kept in memory. A start pulse gives it the byte address of the first descriptor. The block reads that descriptor's eight 32-bit words one at a time over a single-outstanding word-read port. It decodes the words into a set of registered configuration outputs and pulses a start strobe to the transfer engine. It then waits for the engine's completion pulse. If the descriptor names a successor, the block fetches that one and repeats. Otherwise it stops.

A two-bit channel status follows the run. The status is idle before a chain starts and busy while the chain runs. It becomes done or timed-out when the chain ends, and it returns to idle when the status is read. A cycle counter guards each wait on the engine. A select latched at the start pulse tells the block how the link field is encoded: either as a plain byte address, or as an address stored divided by 16 because the list sits in system memory.

Top module: `desc_chain_walker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces status 0 (idle), drops `mem_rd` and `xfer_start`, and abandons any chain in progress. No read and no start follow the reset until a new start pulse arrives.
- R2: With status idle, a `go` pulse makes the status read 1 (busy) after the next clock edge. The first word read is issued at `go_addr`.
- R3: Each descriptor is fetched as 8 reads at byte addresses base, base+4, …, base+28, in rising order. Each read is a single-cycle `mem_rd` pulse, and the next read is not issued until the previous one has returned on `mem_rvalid`.
- R4: The words decode as follows.
  - Word 0: bit 0 gives swap, bit 1 gives direction, and bits 3:2 give width.
  - Word 1: bit 31 gives increment enable, bits 30:29 give increment size, and bits 15:0 give length.
  - Word 2: the whole word is the peripheral address.
  - Word 3: bits 2:0 give access delay, bits 6:4 give burst, and bits 31:16 give the extended address.
  - Word 4: bit 31 gives 2D enable and bits 15:0 give repeat count.
  - Word 5: bits 31:16 give line offset and bits 15:0 give row length.
  - Word 6: the whole word is the memory address.
- R5: After the eighth word returns, `xfer_start` is high for exactly one cycle. The configuration outputs already hold the new descriptor's fields in that cycle.
- R6: In word 7, bit 0 is the finish flag and the word with bit 0 cleared is the link. The next descriptor address is the link itself when `list_sys` was 0 at `go`, and the link shifted left by 4 when it was 1.
- R7: On `xfer_done` for a descriptor whose finish flag is 1 or whose link is zero, the status becomes 2 (done) after that edge. Otherwise the next descriptor is fetched.
- R8: If `xfer_done` has not arrived in the TIMEOUT_CYC cycles that start with the `xfer_start` cycle, the status becomes 3 (timeout) and the chain stops. A `xfer_done` in the last of those cycles still yields done.
- R9: A `status_rd` pulse while the status is done or timeout returns it to idle after the next edge. A `status_rd` while the status is busy or idle has no effect, including in the cycle where the chain completes.
- R10: A `go` while the status is busy, done or timeout is ignored. No read is issued for it, and an active chain keeps its own link order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse |
| go_addr | input | 32 | Byte address of the first descriptor |
| list_sys | input | 1 | Link encoding select, latched at go (1 = link stored divided by 16) |
| status_rd | input | 1 | Status read pulse |
| status | output | 2 | 0 idle, 1 busy, 2 done, 3 timeout |
| mem_rd | output | 1 | Word read request pulse |
| mem_addr | output | 32 | Word read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_start | output | 1 | Transfer engine start pulse |
| xfer_done | input | 1 | Transfer engine completion pulse |
| cfg_swap | output | 1 | Byte swap enable |
| cfg_dir | output | 1 | Direction |
| cfg_width | output | 2 | Peripheral width code |
| cfg_inc_en | output | 1 | Peripheral address increment enable |
| cfg_inc_size | output | 2 | Increment size code |
| cfg_len | output | 16 | Transfer length |
| cfg_per_addr | output | 32 | Peripheral address |
| cfg_acc_delay | output | 3 | Access delay code |
| cfg_burst | output | 3 | Burst size |
| cfg_ext_addr | output | 16 | Extended address |
| cfg_2d | output | 1 | 2D mode enable |
| cfg_rep_count | output | 16 | Row repeat count |
| cfg_line_off | output | 16 | Gap between rows |
| cfg_row_len | output | 16 | Row length |
| cfg_mem_addr | output | 32 | Memory address |

## Verification
Two functions can fall in the same cycle: the engine's completion pulse and the expiry of the timeout count. The bench provokes the tie by counting cycles from the observed start strobe and raising `xfer_done` exactly in the last counted cycle, which must give done. It then repeats the run with the pulse one cycle later, which must give timeout. A second collision is also judged: a status read raised in the completion cycle must leave the fresh done status standing.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int LINK_SHIFT = 4;
  localparam int HALF_W     = 16;
  localparam int CODE2_W    = 2;
  localparam int CODE3_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2,
    ST_TMO  = 2'd3
  } chan_st_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_REQ,
    F_WAIT,
    F_LOAD,
    F_RUN
  } walk_fsm_e;

  typedef logic [DESC_WORDS-1:0][WORD_W-1:0] desc_words_t;

  typedef struct packed {
    logic               swap;
    logic               dir;
    logic [CODE2_W-1:0] width;
    logic               inc_en;
    logic [CODE2_W-1:0] inc_size;
    logic [HALF_W-1:0]  len;
    logic [WORD_W-1:0]  per_addr;
    logic [CODE3_W-1:0] acc_delay;
    logic [CODE3_W-1:0] burst;
    logic [HALF_W-1:0]  ext_addr;
    logic               two_d;
    logic [HALF_W-1:0]  rep_count;
    logic [HALF_W-1:0]  line_off;
    logic [HALF_W-1:0]  row_len;
    logic [WORD_W-1:0]  mem_addr;
  } xfer_cfg_t;

endpackage

// File: rtl/dcw_desc_store.sv
module dcw_desc_store
  import dcw_pkg::*;
(
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [WORD_W-1:0]     wr_data,
  output desc_words_t           words
);

  // One register per descriptor word, written without reset.
  for (genvar i = 0; i < DESC_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        words[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/dcw_decode.sv
module dcw_decode
  import dcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              sys_sel,
  input  desc_words_t       words,
  output xfer_cfg_t         cfg,
  output logic [WORD_W-1:0] next_addr,
  output logic              last
);

  xfer_cfg_t         cfg_d;
  logic [WORD_W-1:0] link;
  logic [WORD_W-1:0] link_addr;
  logic              is_last;
  logic              unused_bits;

  always_comb begin
    cfg_d           = '0;
    cfg_d.swap      = words[0][0];
    cfg_d.dir       = words[0][1];
    cfg_d.width     = words[0][3:2];
    cfg_d.inc_en    = words[1][31];
    cfg_d.inc_size  = words[1][30:29];
    cfg_d.len       = words[1][15:0];
    cfg_d.per_addr  = words[2];
    cfg_d.acc_delay = words[3][2:0];
    cfg_d.burst     = words[3][6:4];
    cfg_d.ext_addr  = words[3][31:16];
    cfg_d.two_d     = words[4][31];
    cfg_d.rep_count = words[4][15:0];
    cfg_d.line_off  = words[5][31:16];
    cfg_d.row_len   = words[5][15:0];
    cfg_d.mem_addr  = words[6];
  end

  // Word 7: bit 0 is the finish flag, the rest is the link.
  assign link      = {words[7][WORD_W-1:1], 1'b0};
  assign link_addr = sys_sel ? (link << LINK_SHIFT) : link;
  assign is_last   = words[7][0] | (link == '0);

  assign unused_bits = ^{words[0][31:4], words[1][28:16], words[3][15:7],
                         words[3][3], words[4][30:16]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      next_addr <= '0;
      last      <= 1'b0;
    end else if (load) begin
      cfg       <= cfg_d;
      next_addr <= link_addr;
      last      <= is_last;
    end
  end

endmodule

// File: rtl/dcw_timer.sv
module dcw_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign expired = run && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import dcw_pkg::*;
#(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic [31:0] go_addr,
  input  logic        list_sys,
  input  logic        status_rd,
  output logic [1:0]  status,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        xfer_start,
  input  logic        xfer_done,
  output logic        cfg_swap,
  output logic        cfg_dir,
  output logic [1:0]  cfg_width,
  output logic        cfg_inc_en,
  output logic [1:0]  cfg_inc_size,
  output logic [15:0] cfg_len,
  output logic [31:0] cfg_per_addr,
  output logic [2:0]  cfg_acc_delay,
  output logic [2:0]  cfg_burst,
  output logic [15:0] cfg_ext_addr,
  output logic        cfg_2d,
  output logic [15:0] cfg_rep_count,
  output logic [15:0] cfg_line_off,
  output logic [15:0] cfg_row_len,
  output logic [31:0] cfg_mem_addr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  walk_fsm_e         fsm;
  chan_st_e          st;
  logic [WORD_W-1:0] base;
  logic [IDX_W-1:0]  idx;
  logic              sys_sel;
  desc_words_t       words;
  xfer_cfg_t         cfg;
  logic [WORD_W-1:0] next_addr;
  logic              last;
  logic              expired;
  logic              wr_en;
  logic              load;
  logic              tmr_run;

  assign wr_en   = (fsm == F_WAIT) && mem_rvalid;
  assign load    = (fsm == F_LOAD);
  assign tmr_run = (fsm == F_RUN);

  dcw_desc_store u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (mem_rdata),
    .words   (words)
  );

  dcw_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .sys_sel   (sys_sel),
    .words     (words),
    .cfg       (cfg),
    .next_addr (next_addr),
    .last      (last)
  );

  dcw_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clear   (load),
    .run     (tmr_run),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm        <= F_IDLE;
      st         <= ST_IDLE;
      base       <= '0;
      idx        <= '0;
      sys_sel    <= 1'b0;
      mem_rd     <= 1'b0;
      mem_addr   <= '0;
      xfer_start <= 1'b0;
    end else begin
      mem_rd     <= 1'b0;
      xfer_start <= 1'b0;
      case (fsm)
        F_IDLE: begin
          if (go && (st == ST_IDLE)) begin
            base    <= go_addr;
            sys_sel <= list_sys;
            idx     <= '0;
            st      <= ST_BUSY;
            fsm     <= F_REQ;
          end else if (status_rd && ((st == ST_DONE) || (st == ST_TMO))) begin
            st <= ST_IDLE;
          end
        end
        F_REQ: begin
          mem_rd   <= 1'b1;
          mem_addr <= base + WORD_W'({idx, 2'b00});
          fsm      <= F_WAIT;
        end
        F_WAIT: begin
          if (mem_rvalid) begin
            if (idx == LAST_IDX) begin
              fsm <= F_LOAD;
            end else begin
              idx <= idx + 1'b1;
              fsm <= F_REQ;
            end
          end
        end
        F_LOAD: begin
          xfer_start <= 1'b1;
          fsm        <= F_RUN;
        end
        F_RUN: begin
          if (xfer_done) begin
            if (last) begin
              st  <= ST_DONE;
              fsm <= F_IDLE;
            end else begin
              base <= next_addr;
              idx  <= '0;
              fsm  <= F_REQ;
            end
          end else if (expired) begin
            st  <= ST_TMO;
            fsm <= F_IDLE;
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  assign status        = st;
  assign cfg_swap      = cfg.swap;
  assign cfg_dir       = cfg.dir;
  assign cfg_width     = cfg.width;
  assign cfg_inc_en    = cfg.inc_en;
  assign cfg_inc_size  = cfg.inc_size;
  assign cfg_len       = cfg.len;
  assign cfg_per_addr  = cfg.per_addr;
  assign cfg_acc_delay = cfg.acc_delay;
  assign cfg_burst     = cfg.burst;
  assign cfg_ext_addr  = cfg.ext_addr;
  assign cfg_2d        = cfg.two_d;
  assign cfg_rep_count = cfg.rep_count;
  assign cfg_line_off  = cfg.line_off;
  assign cfg_row_len   = cfg.row_len;
  assign cfg_mem_addr  = cfg.mem_addr;

endmodule

// File: rtl/dcw_checks.sv
module dcw_checks (
  input logic       clk,
  input logic       rst,
  input logic       go,
  input logic       status_rd,
  input logic [1:0] status,
  input logic       mem_rd,
  input logic       xfer_start
);

  // R2
  go_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (go && status == 2'd0) |=> (status == 2'd1));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (status_rd && status[1]) |=> (status == 2'd0));

  // R10
  final_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status[1] && !status_rd) |=> $stable(status));

  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || xfer_start) |-> (status == 2'd1));

endmodule

bind desc_chain_walker dcw_checks u_chk (
  .clk        (clk),
  .rst        (rst),
  .go         (go),
  .status_rd  (status_rd),
  .status     (status),
  .mem_rd     (mem_rd),
  .xfer_start (xfer_start)
);

// File: tb/sim_desc_chain_walker.sv
module sim_desc_chain_walker;

  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [31:0] go_addr = '0;
  logic        list_sys = 1'b0;
  logic        status_rd = 1'b0;
  logic [1:0]  status;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        xfer_start;
  logic        xfer_done = 1'b0;
  logic        cfg_swap, cfg_dir, cfg_inc_en, cfg_2d;
  logic [1:0]  cfg_width, cfg_inc_size;
  logic [15:0] cfg_len, cfg_ext_addr, cfg_rep_count, cfg_line_off, cfg_row_len;
  logic [31:0] cfg_per_addr, cfg_mem_addr;
  logic [2:0]  cfg_acc_delay, cfg_burst;

  logic [31:0] bmem [0:255];
  logic [31:0] rd_log [0:63];
  int rd_n = 0;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  desc_chain_walker #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .go(go), .go_addr(go_addr), .list_sys(list_sys),
    .status_rd(status_rd), .status(status), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .xfer_start(xfer_start),
    .xfer_done(xfer_done), .cfg_swap(cfg_swap), .cfg_dir(cfg_dir),
    .cfg_width(cfg_width), .cfg_inc_en(cfg_inc_en), .cfg_inc_size(cfg_inc_size),
    .cfg_len(cfg_len), .cfg_per_addr(cfg_per_addr), .cfg_acc_delay(cfg_acc_delay),
    .cfg_burst(cfg_burst), .cfg_ext_addr(cfg_ext_addr), .cfg_2d(cfg_2d),
    .cfg_rep_count(cfg_rep_count), .cfg_line_off(cfg_line_off),
    .cfg_row_len(cfg_row_len), .cfg_mem_addr(cfg_mem_addr)
  );

  // Memory model: answers each read pulse in the same cycle, logs addresses.
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_rd) begin
        mem_rvalid = 1'b1;
        mem_rdata  = bmem[mem_addr[9:2]];
        if (rd_n < 64) rd_log[rd_n] = mem_addr;
        rd_n++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] addr, input logic [31:0] w7, input logic [31:0] tag);
    bmem[addr[9:2] + 0] = 32'h0000_000B;
    bmem[addr[9:2] + 1] = 32'hC000_0123;
    bmem[addr[9:2] + 2] = 32'hA5A5_0000 | tag;
    bmem[addr[9:2] + 3] = 32'hBEEF_0056;
    bmem[addr[9:2] + 4] = 32'h8000_0007;
    bmem[addr[9:2] + 5] = 32'h0020_0040;
    bmem[addr[9:2] + 6] = 32'h1234_5678;
    bmem[addr[9:2] + 7] = w7;
  endtask

  task automatic pulse_go(input logic [31:0] a, input logic sys);
    go = 1'b1; go_addr = a; list_sys = sys;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_start(input string req);
    int n = 0;
    while (!xfer_start && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, xfer_start}, 32'd1);
  endtask

  // Called in the cycle xfer_start is seen (cycle 1); done is raised in cycle k.
  task automatic done_in(input int k);
    repeat (k - 1) @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic read_status(input string req);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    check(req, {30'd0, status}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 reset status", {30'd0, status}, 32'd0);
    check("R1 reset mem_rd", {31'd0, mem_rd}, 32'd0);
    check("R1 reset xfer_start", {31'd0, xfer_start}, 32'd0);
  endtask

  task automatic t_single;
    put_desc(32'h40, 32'h0000_0001, 32'h10);
    rd_n = 0;
    pulse_go(32'h40, 1'b0);
    check("R2 busy after go", {30'd0, status}, 32'd1);
    wait_start("R5 start seen");
    check("R3 eight reads", rd_n, 8);
    for (int k = 0; k < 8; k++) check("R3 read order", rd_log[k], 32'h40 + 4 * k);
    check("R4 word0", {28'd0, cfg_width, cfg_dir, cfg_swap}, 32'hB);
    check("R4 word1", {13'd0, cfg_inc_en, cfg_inc_size, cfg_len}, {13'd0, 1'b1, 2'd2, 16'h0123});
    check("R4 word2", cfg_per_addr, 32'hA5A5_0010);
    check("R4 word3", {cfg_ext_addr, 2'd0, cfg_burst, 8'd0, cfg_acc_delay},
          {16'hBEEF, 2'd0, 3'd5, 8'd0, 3'd6});
    check("R4 word4", {cfg_2d, cfg_rep_count}, {1'b1, 16'h0007});
    check("R4 word5", {cfg_line_off, cfg_row_len}, 32'h0020_0040);
    check("R4 word6", cfg_mem_addr, 32'h1234_5678);
    @(negedge clk);
    check("R5 start one cycle", {31'd0, xfer_start}, 32'd0);
    // R9: read raised together with completion leaves done standing
    status_rd = 1'b1;
    done_in(1);
    status_rd = 1'b0;
    check("R7 done after final", {30'd0, status}, 32'd2);
    check("R9 read at completion ignored", {30'd0, status}, 32'd2);
    @(negedge clk);
    check("R7 done holds", {30'd0, status}, 32'd2);
    read_status("R9 read clears done");
  endtask

  task automatic t_chain(input logic sys, input logic [31:0] a0, input logic [31:0] a1,
                         input logic [31:0] w7a, input logic [31:0] w7b);
    put_desc(a0, w7a, 32'h1);
    put_desc(a1, w7b, 32'h2);
    rd_n = 0;
    pulse_go(a0, sys);
    wait_start("R5 first start");
    check("R4 first tag", cfg_per_addr, 32'hA5A5_0001);
    done_in(3);
    check("R7 busy mid chain", {30'd0, status}, 32'd1);
    wait_start("R6 second start");
    check("R6 second read base", rd_log[8], a1);
    check("R3 sixteen reads", rd_n, 16);
    check("R4 second tag", cfg_per_addr, 32'hA5A5_0002);
    done_in(2);
    check("R7 done after last", {30'd0, status}, 32'd2);
    read_status("R9 clear after chain");
  endtask

  task automatic t_timeout;
    put_desc(32'h80, 32'h0000_0001, 32'h3);
    pulse_go(32'h80, 1'b0);
    wait_start("R8 start");
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    check("R9 read while busy", {30'd0, status}, 32'd1);
    repeat (TMO - 2) @(negedge clk);
    check("R8 busy in last cycle", {30'd0, status}, 32'd1);
    @(negedge clk);
    check("R8 timeout", {30'd0, status}, 32'd3);
    rd_n = 0;
    pulse_go(32'h80, 1'b0);
    repeat (4) @(negedge clk);
    check("R10 go during timeout no read", rd_n, 0);
    check("R10 timeout holds", {30'd0, status}, 32'd3);
    read_status("R9 clear timeout");
  endtask

  task automatic t_tie;
    put_desc(32'h80, 32'h0000_0001, 32'h4);
    pulse_go(32'h80, 1'b0);
    wait_start("R8 tie start");
    done_in(TMO);
    check("R8 done on last cycle wins", {30'd0, status}, 32'd2);
    read_status("R9 clear after tie");
    pulse_go(32'h80, 1'b0);
    wait_start("R8 late start");
    done_in(TMO + 1);
    check("R8 done one cycle late", {30'd0, status}, 32'd3);
    read_status("R9 clear after late");
  endtask

  task automatic t_go_busy;
    put_desc(32'h000, 32'h0000_00C0, 32'h5);
    put_desc(32'h0C0, 32'h0000_0000, 32'h6);
    rd_n = 0;
    pulse_go(32'h000, 1'b0);
    wait_start("R10 start");
    pulse_go(32'h3C0, 1'b1);
    check("R10 still busy", {30'd0, status}, 32'd1);
    done_in(1);
    wait_start("R10 second start");
    check("R10 chain link kept", rd_log[8], 32'h0C0);
    check("R10 no stray read", rd_n, 16);
    done_in(1);
    check("R7 null link ends", {30'd0, status}, 32'd2);
    read_status("R9 clear");
  endtask

  task automatic t_reset_mid;
    int seen = 0;
    put_desc(32'h40, 32'h0000_0001, 32'h7);
    pulse_go(32'h40, 1'b0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid idle", {30'd0, status}, 32'd0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (mem_rd || xfer_start) seen++;
    end
    check("R1 nothing after reset", seen, 0);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) bmem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain(1'b1, 32'h200, 32'h100, 32'h0000_0010, 32'h0000_0001);
    t_chain(1'b0, 32'h200, 32'h300, 32'h0000_0300, 32'h0000_0000);
    t_timeout();
    t_tie();
    t_go_busy();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

endmodule